// File: doc/BRIEF.md
# Transmit Mailbox Priority Arbiter

This block decides which of a bank of 32 message mailboxes the CAN protocol engine sends next. Each mailbox has an enable bit, a direction bit, an interrupt-mask bit and a 14-bit control word. The control word carries the frame's data length, a remote-request flag and a 6-bit transmit priority. Software raises transmit requests through a write-one-to-set mask. A mailbox competes only while it is enabled, set to transmit and holding a pending request. The winner is the mailbox with the largest priority field. When two priority fields are equal, the higher-numbered mailbox wins.

While no frame is in flight, the candidate is recomputed every cycle. A late request with a higher priority therefore displaces the current choice until the engine signals that it is ready. At launch the arbiter emits a one-cycle strobe with the winning index and freezes that choice. The choice stays frozen until the engine reports the frame as sent or as lost in arbitration.

A sent frame sets the mailbox's acknowledge bit and drops its request. If the mailbox's interrupt mask bit is set, a sent frame also raises a global mailbox interrupt flag. A lost frame keeps its request, so the mailbox competes again.

Top module: `mbx_tx_arbiter`

## Requirements
- R1: After reset, all requests, all acknowledge bits, the interrupt flag, `busy` and `sel_valid` are 0, and all mailboxes are disabled with direction 0 and control words of 0.
- R2: A cycle with `req_set_wr` high sets, on the next edge, the request bit of every mailbox whose bit in `req_set_mask` is 1. Bits that are 0 in the mask leave their request unchanged.
- R3: A mailbox is a candidate only if its enable bit is 1, its direction bit is 0 (transmit) and its request bit is 1. `cand_valid` is 0 when no mailbox qualifies.
- R4: Among candidates, `cand_idx` names the one with the largest priority field, which is bits [13:8] of the control word.
- R5: When the priority fields are equal, the candidate with the highest mailbox number wins.
- R6: A launch happens in a cycle where `busy` is 0, `eng_ready` is 1 and a candidate exists. On the next edge `busy` rises and `sel_valid` pulses for exactly one cycle, with `sel_idx` equal to that candidate. `sel_dlc` shows bits [3:0] and `sel_rtr` shows bit 4 of the selected control word.
- R7: While `busy` is 0 and `eng_ready` is 0, the candidate follows the current state every cycle. A newly requested mailbox of higher priority replaces the previous candidate.
- R8: `tx_done` while `busy` sets the selected mailbox's acknowledge bit, clears its request and drops `busy` on the next edge. `tx_done` has precedence over `tx_lost`.
- R9: `tx_lost` without `tx_done` while `busy` drops `busy` and leaves the request and the acknowledge bits unchanged, so the mailbox competes again.
- R10: Writing `ack_clr_mask` with `ack_clr_wr` clears the acknowledge bits at 1 positions. Bits at 0 positions are unchanged.
- R11: A completion raises `mbx_irq` only if the selected mailbox's interrupt mask bit is 1. `irq_clr` clears the flag, and a completion in the same cycle sets it again.
- R12: While `busy`, no new strobe occurs and `sel_idx` does not change. This holds whatever request or configuration writes arrive, until `tx_done` or `tx_lost`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 32 | New enable bits |
| dir_wr | input | 1 | Write strobe for the direction register |
| dir_wdata | input | 32 | New direction bits (0 = transmit) |
| imask_wr | input | 1 | Write strobe for the interrupt mask register |
| imask_wdata | input | 32 | New interrupt mask bits |
| ctl_wr | input | 1 | Write strobe for one control word |
| ctl_idx | input | 5 | Mailbox whose control word is written |
| ctl_wdata | input | 14 | Control word: [3:0] length, [4] remote flag, [13:8] priority |
| req_set_wr | input | 1 | Request-set strobe |
| req_set_mask | input | 32 | Requests to set (1 = set) |
| ack_clr_wr | input | 1 | Acknowledge-clear strobe |
| ack_clr_mask | input | 32 | Acknowledge bits to clear (1 = clear) |
| irq_clr | input | 1 | Clears the mailbox interrupt flag |
| eng_ready | input | 1 | Engine can accept a new frame |
| tx_done | input | 1 | Engine pulse: selected frame sent |
| tx_lost | input | 1 | Engine pulse: selected frame lost arbitration |
| cand_valid | output | 1 | A candidate currently exists |
| cand_idx | output | 5 | Current candidate mailbox |
| sel_valid | output | 1 | One-cycle launch strobe |
| sel_idx | output | 5 | Mailbox in flight (held) |
| sel_dlc | output | 4 | Data length of the mailbox in flight |
| sel_rtr | output | 1 | Remote flag of the mailbox in flight |
| busy | output | 1 | A frame is in flight |
| tx_req | output | 32 | Pending request bits |
| tx_ack | output | 32 | Transmit acknowledge bits |
| mbx_irq | output | 1 | Global mailbox interrupt flag |

## Verification
Two kinds of internal fault can occur. The first is a corrupted request or acknowledge bit. It appears on `tx_req` or `tx_ack` in the cycle after the edge that stored it, and it moves `cand_idx` at once. The second is a wrong comparison in the priority tree. It shows up combinationally on `cand_idx` in the same cycle, and one edge later on `sel_idx`.

A bad in-flight latch shows up differently: a strobe repeats, `sel_idx` drifts while `busy`, or a completion marks a mailbox other than the launched one. All three are visible within one cycle of the triggering engine pulse. Small priority ranges make ties frequent, so tie-break faults are reached early.

// File: rtl/txarb_pkg.sv
package txarb_pkg;
    // control word layout, decoded by the arbiter and the engine
    localparam int CTL_W     = 14;
    localparam int DLC_LSB   = 0;
    localparam int DLC_W     = 4;
    localparam int RTR_BIT   = 4;
    localparam int PRIO_LSB  = 8;
    localparam int PRIO_W    = 6;

    typedef logic [CTL_W-1:0]  ctl_word_t;
    typedef logic [PRIO_W-1:0] prio_t;

    function automatic prio_t ctl_prio(input ctl_word_t w);
        return w[PRIO_LSB +: PRIO_W];
    endfunction

    function automatic logic [DLC_W-1:0] ctl_dlc(input ctl_word_t w);
        return w[DLC_LSB +: DLC_W];
    endfunction

    function automatic logic ctl_rtr(input ctl_word_t w);
        return w[RTR_BIT];
    endfunction
endpackage

// File: rtl/mbx_cfg_regs.sv
module mbx_cfg_regs
    import txarb_pkg::*;
#(
    parameter int NUM_MBX = 32,
    localparam int IDX_W = $clog2(NUM_MBX)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             en_wr,
    input  logic [NUM_MBX-1:0]               en_wdata,
    input  logic                             dir_wr,
    input  logic [NUM_MBX-1:0]               dir_wdata,
    input  logic                             imask_wr,
    input  logic [NUM_MBX-1:0]               imask_wdata,
    input  logic                             ctl_wr,
    input  logic [IDX_W-1:0]                 ctl_idx,
    input  ctl_word_t                        ctl_wdata,
    output logic [NUM_MBX-1:0]               en_q,
    output logic [NUM_MBX-1:0]               dir_q,
    output logic [NUM_MBX-1:0]               imask_q,
    output logic [NUM_MBX-1:0][CTL_W-1:0]    ctl_q
);
    typedef struct packed {
        logic [NUM_MBX-1:0]            en;
        logic [NUM_MBX-1:0]            dir;
        logic [NUM_MBX-1:0]            imask;
        logic [NUM_MBX-1:0][CTL_W-1:0] ctl;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (en_wr)    cfg_d.en    = en_wdata;
        if (dir_wr)   cfg_d.dir   = dir_wdata;
        if (imask_wr) cfg_d.imask = imask_wdata;
        if (ctl_wr)   cfg_d.ctl[ctl_idx] = ctl_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign en_q    = cfg_q.en;
    assign dir_q   = cfg_q.dir;
    assign imask_q = cfg_q.imask;
    assign ctl_q   = cfg_q.ctl;
endmodule

// File: rtl/mbx_pick_tree.sv
module mbx_pick_tree
    import txarb_pkg::*;
#(
    parameter int NUM_MBX = 32,
    localparam int IDX_W = $clog2(NUM_MBX),
    localparam int KEY_W = PRIO_W + IDX_W,
    localparam int NODES = 2 * NUM_MBX - 1
) (
    input  logic [NUM_MBX-1:0]            elig,
    input  logic [NUM_MBX-1:0][CTL_W-1:0] ctl,
    output logic                          win_valid,
    output logic [IDX_W-1:0]              win_idx
);
    // key = {priority, index}: index is unique, so the largest key is the
    // largest priority with ties broken toward the higher mailbox number
    logic             nv [NODES];
    logic [KEY_W-1:0] nk [NODES];

    for (genvar i = 0; i < NUM_MBX; i++) begin : g_leaf
        assign nv[NUM_MBX-1+i] = elig[i];
        assign nk[NUM_MBX-1+i] = {ctl_prio(ctl[i]), IDX_W'(i)};
    end

    for (genvar n = 0; n < NUM_MBX - 1; n++) begin : g_node
        logic take_r;
        assign take_r = nv[2*n+2] && (!nv[2*n+1] || (nk[2*n+2] > nk[2*n+1]));
        assign nv[n]  = nv[2*n+1] || nv[2*n+2];
        assign nk[n]  = take_r ? nk[2*n+2] : nk[2*n+1];
    end

    assign win_valid = nv[0];
    assign win_idx   = nk[0][IDX_W-1:0];
endmodule

// File: rtl/mbx_tx_seq.sv
module mbx_tx_seq #(
    parameter int NUM_MBX = 32,
    localparam int IDX_W = $clog2(NUM_MBX)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_set_wr,
    input  logic [NUM_MBX-1:0] req_set_mask,
    input  logic               ack_clr_wr,
    input  logic [NUM_MBX-1:0] ack_clr_mask,
    input  logic               irq_clr,
    input  logic [NUM_MBX-1:0] imask,
    input  logic               eng_ready,
    input  logic               tx_done,
    input  logic               tx_lost,
    input  logic               win_valid,
    input  logic [IDX_W-1:0]   win_idx,
    output logic [NUM_MBX-1:0] req_q,
    output logic [NUM_MBX-1:0] ack_q,
    output logic               irq_q,
    output logic               busy_q,
    output logic               strobe_q,
    output logic [IDX_W-1:0]   sel_q
);
    typedef struct packed {
        logic [NUM_MBX-1:0] req;
        logic [NUM_MBX-1:0] ack;
        logic               irq;
        logic               busy;
        logic               strobe;
        logic [IDX_W-1:0]   sel;
    } seq_t;

    seq_t s_d, s_q;

    logic               sent, finish, launch;
    logic [NUM_MBX-1:0] sel_oh;

    always_comb begin
        sent   = s_q.busy && tx_done;
        finish = s_q.busy && (tx_done || tx_lost);
        launch = !s_q.busy && eng_ready && win_valid;
        sel_oh = NUM_MBX'(1) << s_q.sel;

        s_d = s_q;
        // request bits: completion clears, software set wins
        if (sent)       s_d.req = s_d.req & ~sel_oh;
        if (req_set_wr) s_d.req = s_d.req | req_set_mask;
        // acknowledge bits: software clear, completion set wins
        if (ack_clr_wr) s_d.ack = s_d.ack & ~ack_clr_mask;
        if (sent)       s_d.ack = s_d.ack | sel_oh;
        // global interrupt flag
        if (irq_clr)                 s_d.irq = 1'b0;
        if (sent && imask[s_q.sel])  s_d.irq = 1'b1;
        // in-flight control
        s_d.strobe = launch;
        if (finish) s_d.busy = 1'b0;
        if (launch) begin
            s_d.busy = 1'b1;
            s_d.sel  = win_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_q    = s_q.req;
    assign ack_q    = s_q.ack;
    assign irq_q    = s_q.irq;
    assign busy_q   = s_q.busy;
    assign strobe_q = s_q.strobe;
    assign sel_q    = s_q.sel;
endmodule

// File: rtl/mbx_tx_arbiter.sv
module mbx_tx_arbiter
    import txarb_pkg::*;
#(
    parameter int NUM_MBX = 32,
    localparam int IDX_W = $clog2(NUM_MBX)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_wr,
    input  logic [NUM_MBX-1:0] en_wdata,
    input  logic               dir_wr,
    input  logic [NUM_MBX-1:0] dir_wdata,
    input  logic               imask_wr,
    input  logic [NUM_MBX-1:0] imask_wdata,
    input  logic               ctl_wr,
    input  logic [IDX_W-1:0]   ctl_idx,
    input  logic [CTL_W-1:0]   ctl_wdata,
    input  logic               req_set_wr,
    input  logic [NUM_MBX-1:0] req_set_mask,
    input  logic               ack_clr_wr,
    input  logic [NUM_MBX-1:0] ack_clr_mask,
    input  logic               irq_clr,
    input  logic               eng_ready,
    input  logic               tx_done,
    input  logic               tx_lost,
    output logic               cand_valid,
    output logic [IDX_W-1:0]   cand_idx,
    output logic               sel_valid,
    output logic [IDX_W-1:0]   sel_idx,
    output logic [DLC_W-1:0]   sel_dlc,
    output logic               sel_rtr,
    output logic               busy,
    output logic [NUM_MBX-1:0] tx_req,
    output logic [NUM_MBX-1:0] tx_ack,
    output logic               mbx_irq
);
    logic [NUM_MBX-1:0]            en_q, dir_q, imask_q, elig;
    logic [NUM_MBX-1:0][CTL_W-1:0] ctl_q;
    logic                          win_valid;
    logic [IDX_W-1:0]              win_idx;
    ctl_word_t                     sel_word;

    mbx_cfg_regs #(.NUM_MBX(NUM_MBX)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_wr      (en_wr),
        .en_wdata   (en_wdata),
        .dir_wr     (dir_wr),
        .dir_wdata  (dir_wdata),
        .imask_wr   (imask_wr),
        .imask_wdata(imask_wdata),
        .ctl_wr     (ctl_wr),
        .ctl_idx    (ctl_idx),
        .ctl_wdata  (ctl_wdata),
        .en_q       (en_q),
        .dir_q      (dir_q),
        .imask_q    (imask_q),
        .ctl_q      (ctl_q)
    );

    // transmit-direction, enabled, requested
    assign elig = en_q & ~dir_q & tx_req;

    mbx_pick_tree #(.NUM_MBX(NUM_MBX)) u_pick (
        .elig     (elig),
        .ctl      (ctl_q),
        .win_valid(win_valid),
        .win_idx  (win_idx)
    );

    mbx_tx_seq #(.NUM_MBX(NUM_MBX)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_set_wr  (req_set_wr),
        .req_set_mask(req_set_mask),
        .ack_clr_wr  (ack_clr_wr),
        .ack_clr_mask(ack_clr_mask),
        .irq_clr     (irq_clr),
        .imask       (imask_q),
        .eng_ready   (eng_ready),
        .tx_done     (tx_done),
        .tx_lost     (tx_lost),
        .win_valid   (win_valid),
        .win_idx     (win_idx),
        .req_q       (tx_req),
        .ack_q       (tx_ack),
        .irq_q       (mbx_irq),
        .busy_q      (busy),
        .strobe_q    (sel_valid),
        .sel_q       (sel_idx)
    );

    assign cand_valid = win_valid;
    assign cand_idx   = win_idx;
    assign sel_word   = ctl_q[sel_idx];
    assign sel_dlc    = ctl_dlc(sel_word);
    assign sel_rtr    = ctl_rtr(sel_word);
endmodule

// File: rtl/mbx_tx_arbiter_chk.sv
module mbx_tx_arbiter_chk #(
    parameter int NUM_MBX = 32,
    localparam int IDX_W = $clog2(NUM_MBX)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_MBX-1:0] en_q,
    input logic [NUM_MBX-1:0] dir_q,
    input logic [NUM_MBX-1:0] tx_req,
    input logic [NUM_MBX-1:0] tx_ack,
    input logic               mbx_irq,
    input logic               busy,
    input logic               sel_valid,
    input logic [IDX_W-1:0]   sel_idx,
    input logic               cand_valid,
    input logic [IDX_W-1:0]   cand_idx,
    input logic               tx_done,
    input logic               tx_lost,
    input logic               req_set_wr,
    input logic [NUM_MBX-1:0] req_set_mask
);
    // R3
    cand_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |-> (en_q[cand_idx] && !dir_q[cand_idx] && tx_req[cand_idx]));

    // R6
    launch_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> sel_valid);

    // R6
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |=> !sel_valid);

    // R12
    hold_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tx_done && !tx_lost) |=> (busy && !sel_valid && $stable(sel_idx)));

    // R8
    done_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tx_done && !req_set_wr) |=>
            (!busy && tx_ack[$past(sel_idx)] && !tx_req[$past(sel_idx)]));

    // R9
    lost_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tx_lost && !tx_done) |=> (!busy && tx_req[$past(sel_idx)]));

    // R2
    req_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_set_wr |=> ((tx_req & $past(req_set_mask)) == $past(req_set_mask)));

    // R11
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mbx_irq && !(busy && tx_done)) |=> !mbx_irq);
endmodule

bind mbx_tx_arbiter mbx_tx_arbiter_chk #(.NUM_MBX(NUM_MBX)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_q        (en_q),
    .dir_q       (dir_q),
    .tx_req      (tx_req),
    .tx_ack      (tx_ack),
    .mbx_irq     (mbx_irq),
    .busy        (busy),
    .sel_valid   (sel_valid),
    .sel_idx     (sel_idx),
    .cand_valid  (cand_valid),
    .cand_idx    (cand_idx),
    .tx_done     (tx_done),
    .tx_lost     (tx_lost),
    .req_set_wr  (req_set_wr),
    .req_set_mask(req_set_mask)
);

// File: tb/mbx_tx_arbiter_test.sv
`timescale 1ns/1ps
module mbx_tx_arbiter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_wr = 0, dir_wr = 0, imask_wr = 0, ctl_wr = 0;
    logic [31:0] en_wdata = 0, dir_wdata = 0, imask_wdata = 0;
    logic [4:0]  ctl_idx = 0;
    logic [13:0] ctl_wdata = 0;
    logic        req_set_wr = 0, ack_clr_wr = 0, irq_clr = 0;
    logic [31:0] req_set_mask = 0, ack_clr_mask = 0;
    logic        eng_ready = 0, tx_done = 0, tx_lost = 0;
    logic        cand_valid, sel_valid, sel_rtr, busy, mbx_irq;
    logic [4:0]  cand_idx, sel_idx;
    logic [3:0]  sel_dlc;
    logic [31:0] tx_req, tx_ack;

    int checks = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    mbx_tx_arbiter uut (.*);

    // bench model of the block state
    logic [31:0] m_en = 0, m_dir = 0, m_imask = 0, m_req = 0, m_ack = 0;
    logic [13:0] m_ctl [32];
    logic        m_irq = 0, m_busy = 0, m_strobe = 0;
    logic [4:0]  m_sel = 0;

    function automatic logic [5:0] prio_of(input logic [13:0] w);
        return w[13:8];
    endfunction

    // winner: scan upward, >= makes the higher index win ties (R4, R5)
    function automatic logic [5:0] model_pick(output logic found);
        logic [4:0] best = 0;
        found = 1'b0;
        for (int i = 0; i < 32; i++) begin
            if (m_en[i] && !m_dir[i] && m_req[i]) begin
                if (!found || prio_of(m_ctl[i]) >= prio_of(m_ctl[best])) best = 5'(i);
                found = 1'b1;
            end
        end
        return {1'b0, best};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        logic        f, sent, fin, launch;
        logic [5:0]  w;
        logic [31:0] oh;
        w      = model_pick(f);
        sent   = m_busy && tx_done;
        fin    = m_busy && (tx_done || tx_lost);
        launch = !m_busy && eng_ready && f;
        oh     = 32'd1 << m_sel;
        if (sent && m_imask[m_sel]) m_irq = 1'b1;
        else if (irq_clr)           m_irq = 1'b0;
        if (sent)       m_req = m_req & ~oh;
        if (req_set_wr) m_req = m_req | req_set_mask;
        if (ack_clr_wr) m_ack = m_ack & ~ack_clr_mask;
        if (sent)       m_ack = m_ack | oh;
        m_strobe = launch;
        if (fin) m_busy = 1'b0;
        if (launch) begin
            m_busy = 1'b1;
            m_sel  = w[4:0];
        end
        if (en_wr)    m_en    = en_wdata;
        if (dir_wr)   m_dir   = dir_wdata;
        if (imask_wr) m_imask = imask_wdata;
        if (ctl_wr)   m_ctl[ctl_idx] = ctl_wdata;
    endtask

    task automatic compare_all();
        logic       f;
        logic [5:0] w;
        w = model_pick(f);
        chk("R2 R8 tx_req", tx_req, m_req);
        chk("R8 R10 tx_ack", tx_ack, m_ack);
        chk("R11 mbx_irq", 32'(mbx_irq), 32'(m_irq));
        chk("R6 R9 busy", 32'(busy), 32'(m_busy));
        chk("R6 R12 sel_valid", 32'(sel_valid), 32'(m_strobe));
        chk("R3 cand_valid", 32'(cand_valid), 32'(f));
        if (f) chk("R4 R5 R7 cand_idx", 32'(cand_idx), 32'(w[4:0]));
        if (m_busy) begin
            chk("R12 sel_idx", 32'(sel_idx), 32'(m_sel));
            chk("R6 sel_dlc", 32'(sel_dlc), 32'(m_ctl[m_sel][3:0]));
            chk("R6 sel_rtr", 32'(sel_rtr), 32'(m_ctl[m_sel][4]));
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic quiet();
        en_wr = 0; dir_wr = 0; imask_wr = 0; ctl_wr = 0;
        req_set_wr = 0; ack_clr_wr = 0; irq_clr = 0;
        tx_done = 0; tx_lost = 0;
    endtask

    task automatic wr_ctl(input int idx, input int prio, input bit rtr, input int dlc);
        ctl_wr = 1; ctl_idx = 5'(idx);
        ctl_wdata = {6'(prio), 3'b000, rtr, 4'(dlc)};
        tick();
        ctl_wr = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 32; i++) m_ctl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 tx_req", tx_req, 32'h0);
        chk("R1 tx_ack", tx_ack, 32'h0);
        chk("R1 flags", {28'h0, busy, sel_valid, mbx_irq, cand_valid}, 32'h0);

        // directed setup
        en_wr = 1; en_wdata = 32'hFFFF_FFFF;
        imask_wr = 1; imask_wdata = 32'h0000_0200;
        tick(); quiet();
        wr_ctl(3, 5, 0, 3);
        wr_ctl(9, 5, 1, 8);
        wr_ctl(2, 7, 0, 1);

        // R5 tie between 3 and 9
        req_set_wr = 1; req_set_mask = 32'h0000_0208;
        tick(); quiet();
        chk("R5 tie goes high", 32'(cand_idx), 32'd9);

        // R7 higher priority request pre-empts while not ready; R4
        req_set_wr = 1; req_set_mask = 32'h0000_0004;
        tick(); quiet();
        chk("R7 R4 preempt", 32'(cand_idx), 32'd2);

        // R6 launch
        eng_ready = 1;
        tick();
        chk("R6 strobe", {sel_valid, 3'b0, sel_idx}, {1'b1, 3'b0, 5'd2});
        // R12 request during flight changes nothing selected
        req_set_wr = 1; req_set_mask = 32'h0000_0020;
        tick(); quiet();
        chk("R12 held", {sel_valid, busy, 2'b0, sel_idx}, {1'b0, 1'b1, 2'b0, 5'd2});

        // R9 lost keeps request
        tx_lost = 1;
        tick(); quiet();
        chk("R9 lost", {busy, tx_req[2], tx_ack[2]}, 3'b010);
        tick();
        chk("R9 relaunch", {sel_valid, sel_idx}, {1'b1, 5'd2});

        // R8 done, R11 no irq when masked off
        tx_done = 1;
        tick(); quiet();
        chk("R8 done", {busy, tx_req[2], tx_ack[2]}, 3'b001);
        chk("R11 masked", 32'(mbx_irq), 32'd0);
        tick();
        chk("R6 next launch", {sel_valid, sel_idx}, {1'b1, 5'd9});
        chk("R6 dlc rtr", {sel_rtr, sel_dlc}, {1'b1, 4'd8});
        eng_ready = 0;
        tx_done = 1;
        tick(); quiet();
        chk("R11 irq set", 32'(mbx_irq), 32'd1);

        // R10 clear only masked acks
        ack_clr_wr = 1; ack_clr_mask = 32'h0000_0004;
        tick(); quiet();
        chk("R10 ack clear", tx_ack, 32'h0000_0200);
        irq_clr = 1;
        tick(); quiet();
        chk("R11 irq clear", 32'(mbx_irq), 32'd0);

        // R3 receive-direction mailbox is not a candidate
        dir_wr = 1; dir_wdata = 32'h0000_0008;
        tick(); quiet();
        chk("R3 dir excludes", {cand_valid, 2'b0, cand_idx}, {1'b1, 2'b0, 5'd5});

        // random phase
        for (int c = 0; c < 4000; c++) begin
            en_wr = ($urandom % 40) == 0;  en_wdata = $urandom | $urandom;
            dir_wr = ($urandom % 40) == 0; dir_wdata = $urandom & $urandom & $urandom;
            imask_wr = ($urandom % 30) == 0; imask_wdata = $urandom;
            ctl_wr = ($urandom % 4) == 0; ctl_idx = 5'($urandom);
            ctl_wdata = {(($urandom % 5) == 0) ? 6'($urandom) : 6'($urandom % 4),
                         3'b000, 1'($urandom), 4'($urandom)};
            req_set_wr = ($urandom % 3) == 0; req_set_mask = $urandom & $urandom;
            ack_clr_wr = ($urandom % 5) == 0; ack_clr_mask = $urandom;
            irq_clr = ($urandom % 8) == 0;
            eng_ready = ($urandom % 3) != 0;
            tx_done = ($urandom % 4) == 0;
            tx_lost = ($urandom % 10) == 0;
            tick();
        end
        quiet();
        eng_ready = 0;
        tick();

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule